// File: doc/BRIEF.md
# Switching Interval Tracker and Gate-Current Channel Selector

This block is the digital core of a current-shaping gate driver for a power transistor that switches an inductive load. It watches the gate on/off command and three comparator levels that report the transistor's operating point. From them it works out which of eight switching intervals is under way: four while the device turns on and four while it turns off. For each interval it raises a set of channel enables. Three enables feed the turn-on current source and three feed the turn-off current sink, so the gate current in each interval is the sum of the enabled weighted channels.

The comparator levels and the command are asynchronous to the block clock and are brought in through synchronizer stages. Each of the three transition flags can only be set while the command is high and only be cleared while it is low. Once a flag has moved, it holds its state, so comparator ringing around its reference cannot disturb it. The interval code and the six enables leave the block from registers.

Top module: `gate_seq_ctrl`

## Requirements
- R1: After reset, all three flags are clear and the command is taken as low. `phase` is 7, `src_en` is 3'b000 and `snk_en` is 3'b100.
- R2: Flag A follows `cmp_gate_above`. It sets when that input is 1 while the command is 1. It clears when that input is 0 while the command is 0.
- R3: Flags B and C follow `cmp_drain_leaving` and `cmp_drain_settled` by the same rule as flag A.
- R4: A comparator level outside its window has no effect. A 1 while the command is 0 never sets a flag, and a 0 while the command is 1 never clears one.
- R5: A flag holds after its first qualifying trigger. Toggling of its comparator within the same command level leaves it unchanged.
- R6: The `phase` code is set by the command and the flags, with C ranked above B and B above A. With the command at 1: C gives 3, else B gives 2, else A gives 1, else 0. With the command at 0: C gives 4, else B gives 5, else A gives 6, else 7.
- R7: In the turn-on phases, `src_en` bit0 is channel 1, bit1 is channel 2 and bit2 is channel 3. The values are 3'b011 in phases 0 and 3, 3'b010 in phase 1, and 3'b110 in phase 2.
- R8: In the turn-off phases, `snk_en` bit0 is channel 4, bit1 is channel 5 and bit2 is channel 6. The values are 3'b101 in phase 4, 3'b110 in phase 5, and 3'b100 in phases 6 and 7.
- R9: `snk_en` is 0 in every turn-on phase, and `src_en` is 0 in every turn-off phase.
- R10: An input change shows at the outputs exactly SYNC_STAGES+1 clock cycles later (3 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gate_cmd | input | 1 | Gate command: 1 turns the device on, 0 turns it off |
| cmp_gate_above | input | 1 | Gate voltage is above threshold |
| cmp_drain_leaving | input | 1 | Drain voltage has moved below its upper reference |
| cmp_drain_settled | input | 1 | Drain voltage is at or below its lower reference |
| phase | output | 3 | Current interval code |
| src_en | output | 3 | Turn-on source channel enables 1..3 |
| snk_en | output | 3 | Turn-off sink channel enables 4..6 |

## Verification
Directed runs walk through a complete turn-on followed by a complete turn-off, so that each of the eight phases and its enable pattern is seen in order. A reversal run turns the command around in the middle of a sequence, and a run with out-of-window comparator levels shows that gating alone decides which flags may move. A ringing run toggles a comparator every cycle to separate first-trigger holding from plain level following. A long run of seeded random levels then reaches the non-monotone flag combinations, which test the priority decode. A cycle-exact probe pins the latency.

// File: rtl/gcs_pkg.sv
// Shared types and decode functions for the gate sequence controller.
// Assumes the flag vector order {C, B, A}, i.e. bit2 = drain settled,
// bit1 = drain leaving, bit0 = gate above threshold.
package gcs_pkg;

    typedef enum logic [2:0] {
        PH_ON_DELAY   = 3'd0,
        PH_ON_IRISE   = 3'd1,
        PH_ON_VFALL   = 3'd2,
        PH_ON_FINAL   = 3'd3,
        PH_OFF_DELAY  = 3'd4,
        PH_OFF_VRISE  = 3'd5,
        PH_OFF_IFALL  = 3'd6,
        PH_OFF_FINAL  = 3'd7
    } phase_t;

    // Interval from command and flags, highest-ranked flag wins.
    function automatic phase_t phase_of(input logic cmd, input logic [2:0] fl);
        phase_t p;
        if (cmd) begin
            if (fl[2])      p = PH_ON_FINAL;
            else if (fl[1]) p = PH_ON_VFALL;
            else if (fl[0]) p = PH_ON_IRISE;
            else            p = PH_ON_DELAY;
        end else begin
            if (fl[2])      p = PH_OFF_DELAY;
            else if (fl[1]) p = PH_OFF_VRISE;
            else if (fl[0]) p = PH_OFF_IFALL;
            else            p = PH_OFF_FINAL;
        end
        return p;
    endfunction

    // Source channel enables {ch3, ch2, ch1} for a phase.
    function automatic logic [2:0] src_of(input phase_t p);
        logic [2:0] e;
        case (p)
            PH_ON_DELAY, PH_ON_FINAL: e = 3'b011;
            PH_ON_IRISE:              e = 3'b010;
            PH_ON_VFALL:              e = 3'b110;
            default:                  e = 3'b000;
        endcase
        return e;
    endfunction

    // Sink channel enables {ch6, ch5, ch4} for a phase.
    function automatic logic [2:0] snk_of(input phase_t p);
        logic [2:0] e;
        case (p)
            PH_OFF_DELAY:               e = 3'b101;
            PH_OFF_VRISE:               e = 3'b110;
            PH_OFF_IFALL, PH_OFF_FINAL: e = 3'b100;
            default:                    e = 3'b000;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/gcs_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous levels.
// Assumes bundle members change rarely compared to the clock; every bit
// has the same depth so simultaneous changes arrive together.
module gcs_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the sampled levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/gcs_edge_flag.sv
// Window-gated set/reset flag. Sets on a high trigger while the window
// (command) is high, clears on a low trigger while it is low; otherwise
// holds. Publishes its next state so the output stage can register it.
module gcs_edge_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic win,
    input  logic trig,
    output logic q_nxt
);
    logic q;

    // Next state: only the matching window may move the flag.
    always_comb begin
        q_nxt = win ? (q | trig) : (q & trig);
    end

    // Hold the flag state.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_nxt;
    end

    AST_SET_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(win)); // R4
    AST_CLR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q) |-> !$past(win)); // R4
    AST_HOLD_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(win) && $past(q)) |-> q); // R5
endmodule

// File: rtl/gcs_phase_out.sv
// Registered output stage: decodes the interval from command and flag
// next-states and drives the interval code and both enable groups.
// Assumes inputs are already synchronous to clk.
module gcs_phase_out
    import gcs_pkg::*;
#(
    parameter int N_FLAGS = 3,
    parameter int N_CH    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd,
    input  logic [N_FLAGS-1:0] flags,
    output logic [2:0]         phase,
    output logic [N_CH-1:0]    src_en,
    output logic [N_CH-1:0]    snk_en
);
    phase_t          ph_d, ph_q;
    logic [N_CH-1:0] src_q, snk_q;

    // Combinational interval decode.
    always_comb begin
        ph_d = phase_of(cmd, flags);
    end

    // Register interval and channel selection; reset sits in final discharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_OFF_FINAL;
            src_q <= '0;
            snk_q <= N_CH'(3'b100);
        end else begin
            ph_q  <= ph_d;
            src_q <= src_of(ph_d);
            snk_q <= snk_of(ph_d);
        end
    end

    assign phase  = ph_q;
    assign src_en = src_q;
    assign snk_en = snk_q;

    AST_SIDES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !((|src_q) && (|snk_q))); // R9
    AST_SOURCE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_q[2] |-> src_q[1]); // R7
    AST_SINK_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q[2] |-> snk_q[2]); // R8
    AST_PHASE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q[2] == !$past(cmd)); // R6
endmodule

// File: rtl/gate_seq_ctrl.sv
// Top: synchronizes command and comparators, keeps the three window-gated
// transition flags, and drives interval code plus source/sink channel
// enables. Latency from any input to the outputs is SYNC_STAGES+1 cycles.
module gate_seq_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gate_cmd,
    input  logic       cmp_gate_above,
    input  logic       cmp_drain_leaving,
    input  logic       cmp_drain_settled,
    output logic [2:0] phase,
    output logic [2:0] src_en,
    output logic [2:0] snk_en
);
    localparam int N_FLAGS = 3;
    localparam int N_CH    = 3;
    localparam int N_IN    = N_FLAGS + 1;

    logic [N_IN-1:0]    raw, synced;
    logic [N_FLAGS-1:0] fl_nxt;

    assign raw = {cmp_drain_settled, cmp_drain_leaving, cmp_gate_above, gate_cmd};

    gcs_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (synced)
    );

    // One flag per comparator, all gated by the synchronized command.
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        gcs_edge_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .win  (synced[0]),
            .trig (synced[g+1]),
            .q_nxt(fl_nxt[g])
        );
    end

    gcs_phase_out #(.N_FLAGS(N_FLAGS), .N_CH(N_CH)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (synced[0]),
        .flags (fl_nxt),
        .phase (phase),
        .src_en(src_en),
        .snk_en(snk_en)
    );
endmodule

// File: tb/gate_seq_ctrl_bench.sv
module gate_seq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gate_cmd = 1'b0;
    logic       ga = 1'b0, dl = 1'b0, ds = 1'b0;
    logic [2:0] phase, src_en, snk_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [2:0] mfl = 3'b000;   // model flags {C,B,A}
    logic       mcmd = 1'b0;

    always #10 clk = ~clk;

    gate_seq_ctrl u_gate_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .gate_cmd(gate_cmd),
        .cmp_gate_above(ga), .cmp_drain_leaving(dl), .cmp_drain_settled(ds),
        .phase(phase), .src_en(src_en), .snk_en(snk_en)
    );

    function automatic logic [2:0] e_phase(input logic c, input logic [2:0] f);
        if (c) return f[2] ? 3'd3 : f[1] ? 3'd2 : f[0] ? 3'd1 : 3'd0;
        return f[2] ? 3'd4 : f[1] ? 3'd5 : f[0] ? 3'd6 : 3'd7;
    endfunction

    function automatic logic [2:0] e_src(input logic [2:0] p);
        case (p)
            3'd0, 3'd3: return 3'b011;
            3'd1:       return 3'b010;
            3'd2:       return 3'b110;
            default:    return 3'b000;
        endcase
    endfunction

    function automatic logic [2:0] e_snk(input logic [2:0] p);
        case (p)
            3'd4:       return 3'b101;
            3'd5:       return 3'b110;
            3'd6, 3'd7: return 3'b100;
            default:    return 3'b000;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Drive a new input set at a falling edge, update the model, hold.
    task automatic apply(input logic c, input logic a, input logic b,
                         input logic s, input int hold);
        @(negedge clk);
        gate_cmd = c; ga = a; dl = b; ds = s;
        mcmd = c;
        if (c) mfl = mfl | {s, b, a};
        else   mfl = mfl & {s, b, a};
        repeat (hold - 1) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        logic [2:0] ep;
        ep = e_phase(mcmd, mfl);
        chk(req, "phase", phase, ep);
        chk(mcmd ? "R7" : "R8", "enables", mcmd ? src_en : snk_en,
            mcmd ? e_src(ep) : e_snk(ep));
        chk("R9", "idle side", mcmd ? snk_en : src_en, 3'b000);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5EED_1234);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "phase", phase, 3'd7);
        chk("R1", "src_en", src_en, 3'b000);
        chk("R1", "snk_en", snk_en, 3'b100);

        // R10 latency: command rise visible after exactly 3 edges
        @(negedge clk);
        gate_cmd = 1'b1; mcmd = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk("R10", "before latency", phase, 3'd7);
        @(posedge clk); #1;
        chk("R10", "at latency", phase, 3'd0);
        repeat (3) @(negedge clk);

        // Full turn-on then turn-off, R2 and R3
        apply(1, 0, 0, 0, 4); check_all("R6");
        apply(1, 1, 0, 0, 4); check_all("R2");
        apply(1, 1, 1, 0, 4); check_all("R3");
        apply(1, 1, 1, 1, 4); check_all("R3");
        apply(0, 1, 1, 1, 4); check_all("R6");
        apply(0, 1, 1, 0, 4); check_all("R3");
        apply(0, 1, 0, 0, 4); check_all("R3");
        apply(0, 0, 0, 0, 4); check_all("R2");

        // R4 out-of-window: high levels with command low set nothing
        apply(0, 1, 1, 1, 5); check_all("R4");
        chk("R4", "still final discharge", phase, 3'd7);
        // and low levels with command high clear nothing
        apply(1, 1, 1, 0, 4);
        apply(1, 0, 0, 0, 5); check_all("R4");
        chk("R4", "flags kept", phase, 3'd2);

        // Reversal mid turn-on: command drops while gate still above
        apply(0, 1, 0, 0, 4); check_all("R6");
        chk("R6", "reversal", phase, 3'd6);
        apply(0, 0, 0, 0, 4); check_all("R6");

        // R5 ringing on the gate comparator during turn-on
        apply(1, 1, 0, 0, 4);
        for (int i = 0; i < 20; i++) apply(1, i[0], 0, 0, 1);
        apply(1, 0, 0, 0, 4); check_all("R5");
        chk("R5", "ringing ignored", phase, 3'd1);
        // ringing on drain-settled during turn-off after clearing
        apply(1, 1, 1, 1, 4);
        apply(0, 1, 1, 0, 4);
        for (int i = 0; i < 20; i++) apply(0, 1, 1, i[0], 1);
        apply(0, 1, 1, 1, 4); check_all("R5");
        chk("R5", "no re-set", phase, 3'd5);

        // Seeded random levels, including non-monotone flag sets (R6)
        for (int i = 0; i < 400; i++) begin
            logic c;
            c = ($urandom % 4 == 0) ? ~mcmd : mcmd;
            apply(c, 1'($urandom), 1'($urandom), 1'($urandom), 4 + int'($urandom % 3));
            check_all("R6");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule